// File: doc/BRIEF.md
# Sleep and Wake Clock Sequencer

This block manages the low-power sleep state of a small processor core and the order in which clocks return after wake-up. A sleep request strobe puts the core to sleep, but only while the idle-select bit is 0. On entry the main oscillator is switched off, the CPU and peripheral clock gates close and the primary-ready status drops. The internal RC oscillator stays on only if the watchdog needs it. The low-power timer oscillator stays on only if it is enabled.

An interrupt, a reset request or a watchdog time-out ends sleep. If the two-bit source select names the primary oscillator, the block first counts rising edges of the raw primary oscillator. When the PLL is enabled it then waits a further lock interval, counted in internal-oscillator cycles. The core clocks stay gated for the whole wait, unless two-speed start-up or fail-safe monitoring is enabled. In that case the core runs from the internal oscillator during the wait and is then moved to the primary clock without a glitch.

The block runs on the always-on internal oscillator clock. After its own reset it begins with the same primary start-up wait.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset, `posc_en` is 1, while `cpu_clk_en`, `per_clk_en` and `posc_ready` are 0, because the block starts in the primary start-up wait.
- R2: A `sleep_req` pulse while `idle_sel` is 1 is ignored: the clock gates stay open.
- R3: A `sleep_req` pulse in run mode with `idle_sel` at 0 is acted on at the next clock edge. From then on `posc_en`, `cpu_clk_en`, `per_clk_en` and `posc_ready` are 0.
- R4: During sleep, `intosc_en` equals `wdt_en`. `lpt_osc_en` is 1 when `lpt_en` is 1 or `clk_src` is 01.
- R5: Any one of `wake_int`, `wake_rst` or `wake_wdt` ends sleep.
- R6: If `clk_src` is not 00 (01 = low-power timer oscillator, 1x = internal oscillator), the clock gates open one cycle after the wake. `clk_sel_int` is then equal to `clk_src[1]`.
- R7: If `clk_src` is 00 and both `two_speed_en` and `fscm_en` are 0, the clock gates stay closed until `posc_ready` rises.
- R8: If `clk_src` is 00 and either `two_speed_en` or `fscm_en` is 1, the gates are open and `clk_sel_int` is 1 during the start-up wait.
- R9: The wait after a wake into the primary source lasts OST_EDGES rising edges of `posc_in`. When `pll_en` is 1, PLL_CYCLES clock cycles are added.
- R10: `posc_ready` is 1 only while the primary clock drives the core: the gates are open and `clk_sel_int` is 0.
- R11: When the core moves from the internal oscillator to the primary clock, the gates are closed in the cycle before `posc_ready` rises. That cycle begins only when `posc_in` is sampled low.
- R12: The wake sequence does not alter the source choice: after a wake the core runs from the source that `clk_src` selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| sleep_req | input | 1 | Sleep request strobe |
| idle_sel | input | 1 | 1 blocks sleep entry |
| clk_src | input | 2 | Clock source: 00 primary, 01 low-power timer, 1x internal |
| wdt_en | input | 1 | Watchdog enabled |
| lpt_en | input | 1 | Low-power timer oscillator enabled |
| two_speed_en | input | 1 | Run from internal oscillator during start-up |
| fscm_en | input | 1 | Fail-safe clock monitoring enabled |
| wake_int | input | 1 | Enabled interrupt wake event |
| wake_rst | input | 1 | Reset wake event |
| wake_wdt | input | 1 | Watchdog time-out wake event |
| posc_in | input | 1 | Raw primary oscillator signal |
| pll_en | input | 1 | PLL in use on the primary path |
| posc_en | output | 1 | Primary oscillator enable |
| intosc_en | output | 1 | Internal RC oscillator enable |
| lpt_osc_en | output | 1 | Low-power timer oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| clk_sel_int | output | 1 | Core clock mux selects the internal oscillator |
| posc_ready | output | 1 | Primary clock is driving the core |

## Verification
The assertions assume that `clk_src` changes only during sleep and never during run mode. A change during run mode could raise `posc_ready` without the guarded switch. The stimulus therefore sets up each new configuration while the block is asleep and only then issues the wake. The assertions also assume that `posc_in` runs slower than half the `clk` rate, so that no edge is lost; the bench uses a period of six clock cycles. The sweep covers every source select, every combination of the two start-up options, both PLL settings and all three wake sources.

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq #(
  parameter int OST_EDGES  = 1024,
  parameter int PLL_CYCLES = 16000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       idle_sel,
  input  logic [1:0] clk_src,
  input  logic       wdt_en,
  input  logic       lpt_en,
  input  logic       two_speed_en,
  input  logic       fscm_en,
  input  logic       wake_int,
  input  logic       wake_rst,
  input  logic       wake_wdt,
  input  logic       posc_in,
  input  logic       pll_en,
  output logic       posc_en,
  output logic       intosc_en,
  output logic       lpt_osc_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       clk_sel_int,
  output logic       posc_ready
);
  localparam int MAXC = (OST_EDGES > PLL_CYCLES) ? OST_EDGES : PLL_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [2:0] S_RUN = 3'd0, S_SLEEP = 3'd1, S_OST = 3'd2,
                         S_PLL = 3'd3, S_SWO = 3'd4, S_GAP = 3'd5;

  logic [2:0]    state;
  logic [CW-1:0] cnt;
  logic [2:0]    psync;

  wire fast     = two_speed_en | fscm_en;
  wire wake_any = wake_int | wake_rst | wake_wdt;
  wire prim     = (clk_src == 2'b00);
  wire posc_s   = psync[1];
  wire posc_up  = psync[1] & ~psync[2];
  wire ost_done = posc_up && (cnt == CW'(OST_EDGES - 1));
  wire pll_done = (cnt == CW'(PLL_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psync <= '0;
    else        psync <= {psync[1:0], posc_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OST;
      cnt   <= '0;
    end else begin
      case (state)
        S_RUN:   if (sleep_req && !idle_sel) state <= S_SLEEP;
        S_SLEEP: if (wake_any) begin
                   state <= prim ? S_OST : S_RUN;
                   cnt   <= '0;
                 end
        S_OST:   if (ost_done) begin
                   cnt   <= '0;
                   state <= pll_en ? S_PLL : (fast ? S_SWO : S_RUN);
                 end else if (posc_up) cnt <= cnt + 1'b1;
        S_PLL:   if (pll_done) state <= fast ? S_SWO : S_RUN;
                 else          cnt   <= cnt + 1'b1;
        S_SWO:   if (!posc_s) state <= S_GAP;
        S_GAP:   state <= S_RUN;
        default: state <= S_OST;
      endcase
    end
  end

  wire waiting = (state == S_OST) || (state == S_PLL);

  assign lpt_osc_en  = lpt_en | (clk_src == 2'b01);
  assign posc_en     = (state == S_RUN) ? prim : (state != S_SLEEP);
  assign posc_ready  = (state == S_RUN) && prim;
  assign cpu_clk_en  = (state == S_RUN) || (state == S_SWO) || (waiting && fast);
  assign per_clk_en  = cpu_clk_en;
  assign clk_sel_int = (state == S_RUN) ? clk_src[1] :
                       ((state == S_SWO) || (waiting && fast));
  always_comb begin
    case (state)
      S_RUN:   intosc_en = clk_src[1] | wdt_en | fscm_en;
      S_SLEEP: intosc_en = wdt_en;
      S_OST:   intosc_en = fast | wdt_en;
      default: intosc_en = 1'b1;
    endcase
  end
endmodule

module sleep_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_run,
  input logic       in_sleep,
  input logic       sleep_req,
  input logic       idle_sel,
  input logic [1:0] clk_src,
  input logic       wdt_en,
  input logic       lpt_en,
  input logic       two_speed_en,
  input logic       fscm_en,
  input logic       posc_en,
  input logic       intosc_en,
  input logic       lpt_osc_en,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       clk_sel_int,
  input logic       posc_ready
);
  // R2
  idle_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req && idle_sel) |=> cpu_clk_en);
  // R3
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> (!posc_en && !cpu_clk_en && !per_clk_en && !posc_ready));
  // R4
  keepalive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> (intosc_en == wdt_en && lpt_osc_en == (lpt_en || clk_src == 2'b01)));
  // R7
  gated_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_speed_en && !fscm_en && posc_en && !posc_ready) |-> !cpu_clk_en);
  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    posc_ready |-> (cpu_clk_en && !clk_sel_int));
  // R11
  switch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(posc_ready) |-> !$past(cpu_clk_en));
endmodule

bind sleep_wake_seq sleep_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_run(state == S_RUN), .in_sleep(state == S_SLEEP),
  .sleep_req(sleep_req), .idle_sel(idle_sel), .clk_src(clk_src),
  .wdt_en(wdt_en), .lpt_en(lpt_en), .two_speed_en(two_speed_en), .fscm_en(fscm_en),
  .posc_en(posc_en), .intosc_en(intosc_en), .lpt_osc_en(lpt_osc_en),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .clk_sel_int(clk_sel_int), .posc_ready(posc_ready)
);

// File: tb/sleep_wake_seq_tb.sv
module sleep_wake_seq_tb;
  localparam int OST  = 1024;
  localparam int PLLC = 40;
  localparam int PPER = 6;

  logic clk = 0, rst_n = 0, posc_in = 0;
  logic sleep_req = 0, idle_sel = 0, wdt_en = 0, lpt_en = 0;
  logic two_speed_en = 0, fscm_en = 0, pll_en = 0;
  logic wake_int = 0, wake_rst = 0, wake_wdt = 0;
  logic [1:0] clk_src = 2'b00;
  logic posc_en, intosc_en, lpt_osc_en, cpu_clk_en, per_clk_en, clk_sel_int, posc_ready;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;
  always #12 posc_in = ~posc_in;

  sleep_wake_seq #(.OST_EDGES(OST), .PLL_CYCLES(PLLC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_sel(idle_sel),
    .clk_src(clk_src), .wdt_en(wdt_en), .lpt_en(lpt_en),
    .two_speed_en(two_speed_en), .fscm_en(fscm_en), .wake_int(wake_int),
    .wake_rst(wake_rst), .wake_wdt(wake_wdt), .posc_in(posc_in), .pll_en(pll_en),
    .posc_en(posc_en), .intosc_en(intosc_en), .lpt_osc_en(lpt_osc_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .clk_sel_int(clk_sel_int), .posc_ready(posc_ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wait_primary(input string tag, input bit fast, input bit pll);
    int n = 0, exp, ok, gated_ok = 1, prev_en = 0;
    while (!posc_ready && n < 20000) begin
      if (!fast && cpu_clk_en) gated_ok = 0;
      if (n == 100) begin
        chk({tag, " R8 cpu_en"}, cpu_clk_en, fast);
        chk({tag, " R8 sel_int"}, clk_sel_int, fast);
      end
      prev_en = cpu_clk_en;
      n++;
      @(negedge clk);
    end
    exp = OST * PPER + (pll ? PLLC : 0);
    ok = (n >= exp - 10) && (n <= exp + 14);
    if (!ok) chk({tag, " R9 wait"}, n, exp); else chk({tag, " R9 wait"}, 1, 1);
    chk({tag, " R7 gated"}, gated_ok, 1);
    if (fast) chk({tag, " R11 gap"}, prev_en, 0);
    chk({tag, " R10 ready"}, {cpu_clk_en, clk_sel_int}, 2);
    chk({tag, " R12 src"}, clk_sel_int, 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 posc_en", posc_en, 1);
    chk("R1 gates", {cpu_clk_en, per_clk_en}, 0);
    chk("R1 ready", posc_ready, 0);
    rst_n = 1;
    @(negedge clk);
    wait_primary("reset", 0, 0);

    for (int src = 0; src < 4; src++)
      for (int ts = 0; ts < 4; ts++)
        for (int p = 0; p < 2; p++) begin
          int k = src * 8 + ts * 2 + p;
          if (src != 0 && p == 1) continue;
          idle_sel = 1; sleep_req = 1;
          @(negedge clk);
          sleep_req = 0;
          @(negedge clk);
          chk("R2 idle blocks", cpu_clk_en, 1);
          idle_sel = 0; sleep_req = 1;
          @(negedge clk);
          sleep_req = 0;
          chk("R3 gates", {cpu_clk_en, per_clk_en, posc_en, posc_ready}, 0);
          clk_src = 2'(src); two_speed_en = ts[0]; fscm_en = ts[1]; pll_en = p[0];
          wdt_en = k[0]; lpt_en = k[1];
          @(negedge clk);
          chk("R4 intosc", intosc_en, wdt_en);
          chk("R4 lpt", lpt_osc_en, (lpt_en || src == 1) ? 1 : 0);
          repeat (5) @(negedge clk);
          chk("R3 stays asleep", cpu_clk_en, 0);
          case (k % 3)
            0: wake_int = 1;
            1: wake_rst = 1;
            default: wake_wdt = 1;
          endcase
          @(negedge clk);
          wake_int = 0; wake_rst = 0; wake_wdt = 0;
          if (src != 0) begin
            chk("R5 R6 woke", cpu_clk_en, 1);
            chk("R6 sel", clk_sel_int, src >> 1);
            chk("R6 ready", posc_ready, 0);
          end else begin
            chk("R5 wake posc_en", posc_en, 1);
            wait_primary("sweep", ts != 0, p[0]);
          end
        end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule